// File: doc/BRIEF.md
# Power Mode Sequencer

This block is the top-level power and mode state machine of an isolated-link transceiver. It steps the device between six named states: `PM_RESET` (code 0), `PM_STBY` stand-by (1), `PM_REG_ON` regulators enabling (2), `PM_CFG` configuration latch (3), `PM_NORMAL` (4) and `PM_REG_OFF` regulators disabling (5). The first power-up runs Reset → Stand-by → Regulators enabling → Configuration latch → Normal. Later wake-ups run Stand-by → Regulators enabling → Normal and skip the configuration latch. Going to sleep runs Normal → Regulators disabling → Stand-by.

A sticky flag records that the first power-up has completed. Only a full reset clears it. The flag decides where Regulators enabling goes once the main power-on reset is released. The host controls the block through an open-drain active-high disable pin. Holding the pin high in Normal, past a deglitch time, sends the device to sleep. Holding it low in Stand-by, for longer than one stand-by oscillator period, wakes the device. The far side of the isolated link can also wake the device. In that case the block pulls the disable pin low for a fixed window on reaching Normal, to interrupt the host. Once the window ends, the device falls back to sleep unless the host keeps the pin low.

All analog timing is given as parameters counted in system clock cycles: the deglitch time, the oscillator period, the pull-down window and the regulator settle time.

Top module: `pms_seq`

Transitions, by name:
- `T_BOOT`: Reset to Stand-by.
- `T_FIRST`: Stand-by to Regulators enabling while the flag is clear.
- `T_HOST_WAKE` and `T_LINK_WAKE`: Stand-by to Regulators enabling.
- `T_TO_CFG` and `T_TO_NORMAL`: the two exits from Regulators enabling.
- `T_LATCHED`: Configuration latch to Normal.
- `T_SLEEP`: Normal to Regulators disabling.
- `T_DOWN`: Regulators disabling to Stand-by.

## Requirements
- R1: While `rst_n` is low, `state_o` reads 0 (`PM_RESET`) and `cfg_stb_o` and `dis_pull_o` are low. One clock after reset is released, the state is `PM_STBY` (1).
- R2: While the first-power-up flag is clear, Stand-by moves to `PM_REG_ON` (2) on the next clock. Regulators enabling then moves to `PM_CFG` (3), and `PM_CFG` moves to `PM_NORMAL` (4). `PM_CFG` is entered only while the flag is clear.
- R3: `PM_REG_ON` is held while `por_rel` is low. The state is left only when `por_rel` is high and the state has lasted at least SETTLE_CYC+1 cycles.
- R4: `PM_CFG` lasts exactly LAT_OSC×OSC_CYC cycles. `cfg_stb_o` is high for exactly one cycle, which is the first cycle of `PM_NORMAL`. Leaving `PM_CFG` sets the first-power-up flag.
- R5: In `PM_NORMAL`, when `dis_in` is high on DGL_CYC+1 consecutive clocks (with no pull-down active), the block moves to `PM_REG_OFF` (5). A shorter high pulse leaves it in Normal.
- R6: `PM_REG_OFF` is held while `reg_down` is low, and moves to `PM_STBY` on the first clock with `reg_down` high.
- R7: In Stand-by with the flag set, `dis_in` low on OSC_CYC+1 consecutive clocks starts a wake. The wake goes to `PM_REG_ON` and then directly to `PM_NORMAL`. A shorter low pulse does not wake the device.
- R8: A `link_wake` pulse in Stand-by with the flag set starts a wake. After that wake, `dis_pull_o` is high for exactly PD_CYC cycles from the first Normal cycle. A wake started by the host, including one in the same cycle as a link wake, gives no pull-down.
- R9: When the pull-down window ends, the device goes to sleep after the deglitch time if `dis_in` is high. If the host holds `dis_in` low, the device stays in Normal.
- R10: A `link_wake` pulse outside Stand-by has no effect on the state or on `dis_pull_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Full active-low reset; also clears the first-power-up flag |
| dis_in | input | 1 | Level of the open-drain disable pin (1 = disable) |
| link_wake | input | 1 | Wake event from the isolated link receiver |
| por_rel | input | 1 | Main power-on reset released |
| reg_down | input | 1 | Regulators have switched off |
| state_o | output | 3 | Current state code |
| cfg_stb_o | output | 1 | One-cycle configuration latch strobe |
| dis_pull_o | output | 1 | Drive the disable pin low (open-drain pull-down) |

## Verification
The bench models the pin as open-drain: it reads high unless the host or `dis_pull_o` pulls it low. This lets the pull-down window and the host's hold interact the way they do on a board. Disable pulses one cycle shorter than each threshold and pulses exactly at each threshold are applied, which separates a correct deglitch count from an off-by-one count. Three kinds of wake are compared: host-only, link-only, and both in the same cycle. This shows whether the pull-down depends on the wake source. After a link wake, the bench both releases the pin and holds it low, which shows whether the fall-back to sleep depends on the pin level seen after the window.

// File: rtl/pms_pkg.sv
package pms_pkg;

    typedef enum logic [2:0] {
        PM_RESET   = 3'd0,
        PM_STBY    = 3'd1,
        PM_REG_ON  = 3'd2,
        PM_CFG     = 3'd3,
        PM_NORMAL  = 3'd4,
        PM_REG_OFF = 3'd5
    } pm_state_t;

    // counter width able to hold values 0..maxv+1
    function automatic int cnt_w(input int maxv);
        return $clog2(maxv + 2);
    endfunction

endpackage

// File: rtl/pms_timer.sv
module pms_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    // dwell counter: zero in the first cycle of a state, saturates at all ones
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (cnt != '1)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pms_hold_det.sv
module pms_hold_det #(
    parameter int THR = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    output logic held
);
    localparam int W = pms_pkg::cnt_w(THR);

    // held rises when cond has been true on THR+1 consecutive clocks
    generate
        if (THR == 0) begin : g_direct
            assign held = cond;
        end else begin : g_count
            logic [W-1:0] run;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    run <= '0;
                else if (!cond)
                    run <= '0;
                else if (run != W'(THR))
                    run <= run + 1'b1;
            end
            assign held = cond && (run == W'(THR));

            assert_hold_span_R5: assert property (@(posedge clk) disable iff (!rst_n)
                held |-> $past(cond));
        end
    endgenerate
endmodule

// File: rtl/pms_seq.sv
module pms_seq #(
    parameter int DGL_CYC    = 4,
    parameter int OSC_CYC    = 3,
    parameter int PD_CYC     = 10,
    parameter int SETTLE_CYC = 2,
    parameter int LAT_OSC    = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dis_in,
    input  logic       link_wake,
    input  logic       por_rel,
    input  logic       reg_down,
    output logic [2:0] state_o,
    output logic       cfg_stb_o,
    output logic       dis_pull_o
);
    import pms_pkg::*;

    localparam int LAT_CYC = LAT_OSC * OSC_CYC;
    localparam int T_A     = (LAT_CYC > PD_CYC) ? LAT_CYC : PD_CYC;
    localparam int T_MAX   = (T_A > SETTLE_CYC) ? T_A : SETTLE_CYC;
    localparam int TW      = cnt_w(T_MAX);

    pm_state_t   state, nxt;
    logic        first_done;
    logic        link_flag;
    logic        stb_q;
    logic [TW-1:0] dwell;
    logic        pull;
    logic        sleep_req;
    logic        host_wake;
    logic        link_go;

    // dwell timer restarts on every state change
    pms_timer #(.W(TW)) u_dwell (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (nxt != state),
        .cnt   (dwell)
    );

    // disable pin high in Normal past the deglitch time
    pms_hold_det #(.THR(DGL_CYC)) u_hi_det (
        .clk   (clk),
        .rst_n (rst_n),
        .cond  ((state == PM_NORMAL) && dis_in && !pull),
        .held  (sleep_req)
    );

    // disable pin low in Stand-by for more than one oscillator period
    pms_hold_det #(.THR(OSC_CYC)) u_lo_det (
        .clk   (clk),
        .rst_n (rst_n),
        .cond  ((state == PM_STBY) && first_done && !dis_in),
        .held  (host_wake)
    );

    assign link_go = (state == PM_STBY) && first_done && link_wake && !host_wake;
    assign pull    = (state == PM_NORMAL) && link_flag && (dwell < TW'(PD_CYC));

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            PM_RESET:   nxt = PM_STBY;                                  // T_BOOT
            PM_STBY: begin
                if (!first_done)
                    nxt = PM_REG_ON;                                    // T_FIRST
                else if (host_wake || link_go)
                    nxt = PM_REG_ON;                                    // T_HOST_WAKE / T_LINK_WAKE
            end
            PM_REG_ON: begin
                if (por_rel && (dwell >= TW'(SETTLE_CYC)))
                    nxt = first_done ? PM_NORMAL : PM_CFG;              // T_TO_NORMAL / T_TO_CFG
            end
            PM_CFG: begin
                if (dwell == TW'(LAT_CYC - 1))
                    nxt = PM_NORMAL;                                    // T_LATCHED
            end
            PM_NORMAL: begin
                if (sleep_req)
                    nxt = PM_REG_OFF;                                   // T_SLEEP
            end
            PM_REG_OFF: begin
                if (reg_down)
                    nxt = PM_STBY;                                      // T_DOWN
            end
            default:    nxt = PM_RESET;
        endcase
    end

    // state register and sticky flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= PM_RESET;
            first_done <= 1'b0;
            link_flag  <= 1'b0;
            stb_q      <= 1'b0;
        end else begin
            state <= nxt;
            stb_q <= (state == PM_CFG) && (nxt == PM_NORMAL);
            if ((state == PM_CFG) && (nxt == PM_NORMAL))
                first_done <= 1'b1;
            if ((state == PM_STBY) && (nxt == PM_REG_ON))
                link_flag <= link_go;
        end
    end

    // outputs
    always_comb begin
        state_o    = state;
        cfg_stb_o  = stb_q;
        dis_pull_o = pull;
    end

    assert_cfg_only_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PM_CFG) |-> !first_done);

    assert_regon_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != PM_REG_ON) && ($past(state) == PM_REG_ON)) |-> $past(por_rel));

    assert_stb_after_cfg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_stb_o |-> (($past(state) == PM_CFG) && (state == PM_NORMAL)));

    assert_stby_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == PM_STBY) && ($past(state) != PM_STBY)) |->
            (($past(state) == PM_RESET) || ($past(state) == PM_REG_OFF)));

    assert_pull_in_normal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dis_pull_o |-> ((state == PM_NORMAL) && link_flag));

    assert_regoff_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(state) == PM_REG_OFF) && !$past(reg_down)) |-> (state == PM_REG_OFF));
endmodule

// File: tb/pms_seq_bench.sv
module pms_seq_bench;
    import pms_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_low = 1'b1;
    logic link_wake = 1'b0;
    logic por_rel = 1'b0;
    logic reg_down = 1'b0;
    logic dis_pin;
    logic [2:0] state_o;
    logic cfg_stb_o;
    logic dis_pull_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    // open-drain pin: high unless host or block pulls it low
    assign dis_pin = ~(host_low | dis_pull_o);

    pms_seq u_pms_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .dis_in     (dis_pin),
        .link_wake  (link_wake),
        .por_rel    (por_rel),
        .reg_down   (reg_down),
        .state_o    (state_o),
        .cfg_stb_o  (cfg_stb_o),
        .dis_pull_o (dis_pull_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_state(input string tag, input pm_state_t exp);
        chk(state_o == exp, tag, int'(state_o), int'(exp));
    endtask

    // Normal, pin released, no pull: sleep after DGL_CYC+1 clocks, then Stand-by
    task automatic go_sleep();
        host_low = 1'b0;
        tick(4);
        chk_state("R5 still normal before deglitch", PM_NORMAL);
        tick(1);
        chk_state("R5 sleep after deglitch", PM_REG_OFF);
        tick(1);
        chk_state("R6 down to standby", PM_STBY);
    endtask

    task automatic t_reset();
        tick(3);
        chk_state("R1 reset state", PM_RESET);
        chk(cfg_stb_o == 1'b0, "R1 strobe low", cfg_stb_o, 0);
        chk(dis_pull_o == 1'b0, "R1 pull low", dis_pull_o, 0);
        rst_n = 1'b1;
        tick(1);
        chk_state("R1 standby after reset", PM_STBY);
    endtask

    task automatic t_first_power();
        int n;
        tick(1);
        chk_state("R2 first power to regulators on", PM_REG_ON);
        tick(8);
        chk_state("R3 held without por release", PM_REG_ON);
        por_rel = 1'b1;
        tick(1);
        chk_state("R2 config latch entered", PM_CFG);
        n = 0;
        while (state_o == PM_CFG && n < 50) begin
            chk(cfg_stb_o == 1'b0, "R4 no strobe during latch", cfg_stb_o, 0);
            n++;
            tick(1);
        end
        chk(n == 9, "R4 latch length", n, 9);
        chk_state("R2 normal after latch", PM_NORMAL);
        chk(cfg_stb_o == 1'b1, "R4 strobe on first normal cycle", cfg_stb_o, 1);
        tick(1);
        chk(cfg_stb_o == 1'b0, "R4 strobe single cycle", cfg_stb_o, 0);
    endtask

    task automatic t_short_high();
        host_low = 1'b0;
        tick(4);
        host_low = 1'b1;
        tick(10);
        chk_state("R5 short high pulse ignored", PM_NORMAL);
    endtask

    task automatic t_sleep();
        reg_down = 1'b0;
        host_low = 1'b0;
        tick(4);
        chk_state("R5 normal at threshold-1", PM_NORMAL);
        tick(1);
        chk_state("R5 regulators off", PM_REG_OFF);
        tick(5);
        chk_state("R6 held while regulators up", PM_REG_OFF);
        reg_down = 1'b1;
        tick(1);
        chk_state("R6 standby on regulator down", PM_STBY);
    endtask

    task automatic t_short_low();
        host_low = 1'b1;
        tick(3);
        host_low = 1'b0;
        tick(6);
        chk_state("R7 short low pulse no wake", PM_STBY);
    endtask

    task automatic t_host_wake();
        host_low = 1'b1;
        tick(3);
        chk_state("R7 no wake before period", PM_STBY);
        tick(1);
        chk_state("R7 wake to regulators on", PM_REG_ON);
        tick(3);
        chk_state("R7 wake skips config latch", PM_NORMAL);
        chk(dis_pull_o == 1'b0, "R8 host wake no pull", dis_pull_o, 1'b0);
        tick(12);
        chk(dis_pull_o == 1'b0, "R8 host wake no pull later", dis_pull_o, 1'b0);
        go_sleep();
    endtask

    task automatic t_link_release();
        int n;
        host_low = 1'b0;
        link_wake = 1'b1;
        tick(1);
        link_wake = 1'b0;
        chk_state("R8 link wake to regulators on", PM_REG_ON);
        tick(3);
        chk_state("R8 link wake reaches normal", PM_NORMAL);
        n = 0;
        while (dis_pull_o && n < 100) begin
            n++;
            tick(1);
        end
        chk(n == 10, "R8 pull-down window length", n, 10);
        tick(4);
        chk_state("R9 released pin, before deglitch", PM_NORMAL);
        tick(1);
        chk_state("R9 released pin falls to sleep", PM_REG_OFF);
        tick(1);
        chk_state("R9 back in standby", PM_STBY);
    endtask

    task automatic t_link_hold();
        link_wake = 1'b1;
        tick(1);
        link_wake = 1'b0;
        tick(3);
        chk_state("R8 link wake normal (hold case)", PM_NORMAL);
        chk(dis_pull_o == 1'b1, "R8 pull active at entry", dis_pull_o, 1);
        host_low = 1'b1;
        tick(30);
        chk_state("R9 host holds pin, stays normal", PM_NORMAL);
        chk(dis_pull_o == 1'b0, "R8 pull ended", dis_pull_o, 0);
        go_sleep();
    endtask

    task automatic t_both_and_ignore();
        host_low = 1'b1;
        tick(3);
        link_wake = 1'b1;
        tick(1);
        link_wake = 1'b0;
        chk_state("R8 simultaneous wake starts", PM_REG_ON);
        tick(3);
        chk_state("R8 simultaneous wake normal", PM_NORMAL);
        chk(dis_pull_o == 1'b0, "R8 host priority no pull", dis_pull_o, 0);
        link_wake = 1'b1;
        tick(1);
        link_wake = 1'b0;
        tick(3);
        chk_state("R10 link wake in normal ignored", PM_NORMAL);
        chk(dis_pull_o == 1'b0, "R10 no pull from ignored wake", dis_pull_o, 0);
        go_sleep();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_first_power();
        t_short_high();
        t_sleep();
        t_short_low();
        t_host_wake();
        t_link_release();
        t_link_hold();
        t_both_and_ignore();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end
endmodule